// File: doc/BRIEF.md
# System Clock Gating Controller

This block switches a small set of system clocks on and off under software control. Software writes a mask of ones to a set register to start clocks and a mask of ones to a clear register to stop them. A read-only status word shows which clocks are running at that moment. There are three controlled clocks:

- the processor clock, gated from the master clock;
- a USB host clock pair, a full-speed clock and a quarter-rate clock, divided down from one of two PLL sources;
- a double-rate memory clock, gated from a clock running at twice the master rate.

The processor clock stops only at an instruction boundary that the core reports. Any unmasked interrupt restarts it.

Each output is produced by a latch-based gate. The gate's enable is captured while its source clock is low, so an output never carries a shortened pulse. The USB divider divides the selected source by its programmed value plus one, and the quarter-rate clock runs at one quarter of the full-speed rate. While the stored master-clock divider code is zero, the memory clock is held off whatever its enable says. Its enable is kept, so the clock comes back once a non-zero code is written.

Top module: `sysClkGate`

## Requirements
- R1: After reset, the status register (word 2) reads 0x1: bit 0 (processor) is 1, bit 1 (USB host) is 0 and bit 2 (memory) is 0. The USB configuration register (word 3) reads 0x9: divider field in bits 3:0 equal to 9, source select in bit 8 equal to 0. The master divider register (word 4, bits 1:0) reads 0.
- R2: Writing word 0 turns on each clock whose bit is 1 (bit 0 processor, bit 1 USB host, bit 2 memory). Bits written as 0 leave their clock unchanged.
- R3: Writing word 1 turns off the USB host or memory clock for each bit that is 1, with effect at the write edge. Bits written as 0 leave their clock unchanged.
- R4: A processor-clock turn-off takes effect on the first rising edge at which instrDone is 1, counting the write edge itself. Until then, status bit 0 stays 1 and procClk keeps one rising edge per master cycle.
- R5: While the processor clock is stopped, any interrupt with irqReq and irqMask both 1 restarts it at the next edge. An interrupt whose mask bit is 0 leaves it stopped. An unmasked interrupt also cancels a pending turn-off.
- R6: While the memory clock is active, memClk2x gives two rising edges per master cycle.
- R7: While the master divider field is 0, status bit 2 reads 0 and memClk2x stays low, even with the memory enable set. A non-zero divider restores the clock.
- R8: While the USB host clock is on, usbClk48 gives one rising edge per (divider field + 1) selected-source cycles, and usbClk12 gives one per 4×(divider field + 1) cycles.
- R9: Source select bit 8 of word 3 feeds the USB divider from usbSrcB when 1 and from usbSrcA when 0.
- R10: A gated output is low whenever its source clock is low, and it is low throughout while its clock is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; register clock and processor clock source |
| clk2x | input | 1 | Double-rate clock source for the memory clock |
| usbSrcA | input | 1 | USB divider source, select 0 |
| usbSrcB | input | 1 | USB divider source, select 1 |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data for regAddr, combinational |
| irqReq | input | IRQ_W | Interrupt requests |
| irqMask | input | IRQ_W | Per-source wake enable, 1 = may wake |
| instrDone | input | 1 | Core reports an instruction boundary |
| procClk | output | 1 | Gated processor clock |
| usbClk48 | output | 1 | Gated USB full-speed clock |
| usbClk12 | output | 1 | Gated USB quarter-rate clock |
| memClk2x | output | 1 | Gated double-rate memory clock |

## Verification
The bench holds instrDone low across a processor turn-off and confirms that the clock keeps running; a design that gated at once would stop the core mid-instruction. It sends a masked interrupt, an unmasked interrupt, and an unmasked interrupt that lands while a turn-off is still pending. A design that ignored the mask would wake spuriously, and one that kept the pending request would stop the clock right after the wake. It writes a zero master divider while the memory enable is set and counts memory-clock edges, which catches a design that lets the enable bit through regardless. It counts USB edges over windows for several divider values, including zero, and for both sources, which exposes off-by-one divider errors and an inverted select.

// File: rtl/sckPkg.sv
package sckPkg;
  localparam int CLK_N = 3;
  localparam int DIV_W = 4;
  localparam int MDIV_W = 2;
  localparam int ADDR_W = 3;
  localparam int IDX_PROC = 0;
  localparam int IDX_USB = 1;
  localparam int IDX_MEM = 2;
  localparam int USB_SEL_BIT = 8;
  localparam logic [DIV_W-1:0] DIV_RST = 4'd9;
  localparam logic [ADDR_W-1:0] A_ON = 3'd0;
  localparam logic [ADDR_W-1:0] A_OFF = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_USB = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCK = 3'd4;

  typedef struct packed {
    logic [CLK_N-1:0] onMask;
    logic [CLK_N-1:0] offMask;
    logic usbCfgWe;
    logic mckCfgWe;
    logic [DIV_W-1:0] divVal;
    logic srcSel;
    logic [MDIV_W-1:0] mdivVal;
  } strobe_t;
endpackage

// File: rtl/clkGateCell.sv
module clkGateCell (
  input  logic clkIn,
  input  logic en,
  output logic gclk
);
  logic enLat;

  // enable is captured only while the source is low
  always_latch begin
    if (!clkIn) enLat = en;
  end

  assign gclk = clkIn & enLat;
endmodule

// File: rtl/sckCtrl.sv
module sckCtrl
  import sckPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [CLK_N-1:0]  clkActive,
  input  logic [DIV_W-1:0]  usbDiv,
  input  logic              usbSel,
  input  logic [MDIV_W-1:0] mckDiv,
  output strobe_t           strobe,
  output logic [DATA_W-1:0] regRdata
);
  wire unusedWdata = ^regWdata;

  always_comb begin
    strobe = '0;
    strobe.divVal = regWdata[DIV_W-1:0];
    strobe.srcSel = regWdata[USB_SEL_BIT];
    strobe.mdivVal = regWdata[MDIV_W-1:0];
    if (regWe) begin
      case (regAddr)
        A_ON:  strobe.onMask = regWdata[CLK_N-1:0];
        A_OFF: strobe.offMask = regWdata[CLK_N-1:0];
        A_USB: strobe.usbCfgWe = 1'b1;
        A_MCK: strobe.mckCfgWe = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_STAT: regRdata[CLK_N-1:0] = clkActive;
      A_USB: begin
        regRdata[DIV_W-1:0] = usbDiv;
        regRdata[USB_SEL_BIT] = usbSel;
      end
      A_MCK: regRdata[MDIV_W-1:0] = mckDiv;
      default: ;
    endcase
  end
endmodule

// File: rtl/sckData.sv
module sckData
  import sckPkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic              clk,
  input  logic              clk2x,
  input  logic              usbSrcA,
  input  logic              usbSrcB,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [IRQ_W-1:0]  irqReq,
  input  logic [IRQ_W-1:0]  irqMask,
  input  logic              instrDone,
  output logic [CLK_N-1:0]  clkActive,
  output logic [DIV_W-1:0]  usbDiv,
  output logic              usbSel,
  output logic [MDIV_W-1:0] mckDiv,
  output logic              procClk,
  output logic              usbClk48,
  output logic              usbClk12,
  output logic              memClk2x
);
  localparam int GATE_N = 4;

  logic procRun, pendingOff, usbEn, memEn;
  logic wake, offReq, memLive;

  assign wake = |(irqReq & irqMask);
  assign offReq = strobe.offMask[IDX_PROC] | pendingOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      procRun <= 1'b1;
      pendingOff <= 1'b0;
    end else if (wake || strobe.onMask[IDX_PROC]) begin
      procRun <= 1'b1;
      pendingOff <= 1'b0;
    end else if (offReq) begin
      if (instrDone) begin
        procRun <= 1'b0;
        pendingOff <= 1'b0;
      end else begin
        pendingOff <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usbEn <= 1'b0;
      memEn <= 1'b0;
      usbDiv <= DIV_RST;
      usbSel <= 1'b0;
      mckDiv <= '0;
    end else begin
      usbEn <= (usbEn | strobe.onMask[IDX_USB]) & ~strobe.offMask[IDX_USB];
      memEn <= (memEn | strobe.onMask[IDX_MEM]) & ~strobe.offMask[IDX_MEM];
      if (strobe.usbCfgWe) begin
        usbDiv <= strobe.divVal;
        usbSel <= strobe.srcSel;
      end
      if (strobe.mckCfgWe) mckDiv <= strobe.mdivVal;
    end
  end

  assign memLive = memEn & (mckDiv != '0);

  always_comb begin
    clkActive = '0;
    clkActive[IDX_PROC] = procRun;
    clkActive[IDX_USB] = usbEn;
    clkActive[IDX_MEM] = memLive;
  end

  // USB divider, running on the selected source
  logic usbSrc;
  logic [1:0] usbOnSync;
  logic [DIV_W-1:0] divCnt;
  logic [1:0] quarterCnt;
  logic tick48, tick12;

  assign usbSrc = usbSel ? usbSrcB : usbSrcA;

  always_ff @(posedge usbSrc or negedge rstN) begin
    if (!rstN) begin
      usbOnSync <= '0;
      divCnt <= '0;
      quarterCnt <= '0;
      tick48 <= 1'b0;
      tick12 <= 1'b0;
    end else begin
      usbOnSync <= {usbOnSync[0], usbEn};
      if (divCnt >= usbDiv) begin
        divCnt <= '0;
        tick48 <= 1'b1;
        quarterCnt <= quarterCnt + 2'd1;
        tick12 <= (quarterCnt == 2'd3);
      end else begin
        divCnt <= divCnt + 1'b1;
        tick48 <= 1'b0;
        tick12 <= 1'b0;
      end
    end
  end

  logic [GATE_N-1:0] gateSrc, gateEn, gateOut;
  assign gateSrc = {clk2x, usbSrc, usbSrc, clk};
  assign gateEn = {memLive, tick12 & usbOnSync[1], tick48 & usbOnSync[1], procRun};

  for (genvar g = 0; g < GATE_N; g++) begin : gGate
    clkGateCell u_gate (
      .clkIn(gateSrc[g]),
      .en(gateEn[g]),
      .gclk(gateOut[g])
    );
  end

  assign procClk = gateOut[0];
  assign usbClk48 = gateOut[1];
  assign usbClk12 = gateOut[2];
  assign memClk2x = gateOut[3];
endmodule

// File: rtl/sysClkGate.sv
module sysClkGate
  import sckPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W = 8
) (
  input  logic              clk,
  input  logic              clk2x,
  input  logic              usbSrcA,
  input  logic              usbSrcB,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [IRQ_W-1:0]  irqReq,
  input  logic [IRQ_W-1:0]  irqMask,
  input  logic              instrDone,
  output logic              procClk,
  output logic              usbClk48,
  output logic              usbClk12,
  output logic              memClk2x
);
  strobe_t strobe;
  logic [CLK_N-1:0] clkActive;
  logic [DIV_W-1:0] usbDiv;
  logic usbSel;
  logic [MDIV_W-1:0] mckDiv;

  sckCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .clkActive(clkActive), .usbDiv(usbDiv), .usbSel(usbSel), .mckDiv(mckDiv),
    .strobe(strobe), .regRdata(regRdata)
  );

  sckData #(.IRQ_W(IRQ_W)) u_data (
    .clk(clk), .clk2x(clk2x), .usbSrcA(usbSrcA), .usbSrcB(usbSrcB), .rstN(rstN),
    .strobe(strobe), .irqReq(irqReq), .irqMask(irqMask), .instrDone(instrDone),
    .clkActive(clkActive), .usbDiv(usbDiv), .usbSel(usbSel), .mckDiv(mckDiv),
    .procClk(procClk), .usbClk48(usbClk48), .usbClk12(usbClk12), .memClk2x(memClk2x)
  );
endmodule

// File: rtl/sysClkGateChk.sv
module sysClkGateChk #(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             clk2x,
  input logic             rstN,
  input logic             procClk,
  input logic             memClk2x,
  input logic [IRQ_W-1:0] irqReq,
  input logic [IRQ_W-1:0] irqMask,
  input logic             instrDone,
  input logic [2:0]       clkActive,
  input logic [1:0]       mckDiv
);
  // R10: gated processor clock is low while its source is low
  assert_proc_gate_low_R10: assert property (@(posedge clk) disable iff (!rstN) !procClk);

  // R10: gated memory clock is low while its source is low
  assert_mem_gate_low_R10: assert property (@(posedge clk2x) disable iff (!rstN) !memClk2x);

  // R4: the processor clock stops only on an instruction boundary
  assert_stop_at_boundary_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkActive[0]) |-> $past(instrDone));

  // R5: an unmasked interrupt restarts the processor clock
  assert_wake_on_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|(irqReq & irqMask)) |=> clkActive[0]);

  // R7: a zero master divider keeps the memory clock off
  assert_mem_forced_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mckDiv == 2'd0) |-> !clkActive[2]);
endmodule

bind sysClkGate sysClkGateChk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .clk2x(clk2x), .rstN(rstN), .procClk(procClk), .memClk2x(memClk2x),
  .irqReq(irqReq), .irqMask(irqMask), .instrDone(instrDone),
  .clkActive(clkActive), .mckDiv(mckDiv)
);

// File: tb/sysClkGate_bench.sv
`timescale 1ns/100ps
module sysClkGate_bench;
  localparam int DATA_W = 32;
  localparam int IRQ_W = 8;

  logic clk = 0, clk2x = 0, usbSrcA = 0, usbSrcB = 0, rstN = 0;
  logic regWe = 0;
  logic [2:0] regAddr = 0;
  logic [DATA_W-1:0] regWdata = 0;
  logic [DATA_W-1:0] regRdata;
  logic [IRQ_W-1:0] irqReq = 0, irqMask = 0;
  logic instrDone = 0;
  logic procClk, usbClk48, usbClk12, memClk2x;

  int nChecks = 0, nFails = 0;
  int nProc = 0, nMem = 0, n48 = 0, n12 = 0;

  always #5 clk = ~clk;
  initial begin
    #1;
    forever #2.5 clk2x = ~clk2x;
  end
  always #4 usbSrcA = ~usbSrcA;
  always #6 usbSrcB = ~usbSrcB;

  always @(posedge procClk) nProc++;
  always @(posedge memClk2x) nMem++;
  always @(posedge usbClk48) n48++;
  always @(posedge usbClk12) n12++;

  sysClkGate #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_sysClkGate (
    .clk(clk), .clk2x(clk2x), .usbSrcA(usbSrcA), .usbSrcB(usbSrcB), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqReq(irqReq), .irqMask(irqMask), .instrDone(instrDone),
    .procClk(procClk), .usbClk48(usbClk48), .usbClk12(usbClk12), .memClk2x(memClk2x)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic chkRange(input string tag, input int got, input int lo, input int hi);
    nChecks++;
    if (got < lo || got > hi) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0; regWdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    regAddr = a;
    #1;
    d = int'(regRdata);
  endtask

  function automatic int expStatus(input bit p, input bit u, input bit m, input int mdiv);
    return int'(p) | (int'(u) << 1) | ((m && mdiv != 0) ? 4 : 0);
  endfunction

  task automatic countProc(output int n);
    int s;
    @(negedge clk); s = nProc;
    repeat (10) @(negedge clk);
    n = nProc - s;
  endtask

  task automatic countMem(output int n);
    int s;
    @(negedge clk); s = nMem;
    repeat (10) @(negedge clk);
    n = nMem - s;
  endtask

  task automatic countUsb(input int cycles, output int a, output int b);
    int s48, s12;
    @(negedge usbSrcA); s48 = n48; s12 = n12;
    repeat (cycles) @(negedge usbSrcA);
    a = n48 - s48; b = n12 - s12;
  endtask

  initial begin
    #150000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int v, e, a, b, mdiv;
    bit pE, uE, mE;
    void'($urandom(32'h5C6A11));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rd(3'd2, v); chk("R1 status", v, 1);
    rd(3'd3, v); chk("R1 usbcfg", v, 9);
    rd(3'd4, v); chk("R1 mckcfg", v, 0);
    countMem(v); chk("R10 mem off after reset", v, 0);

    // R2/R3 random masks against a model, instrDone held high
    instrDone = 1;
    pE = 1; uE = 0; mE = 0; mdiv = 0;
    for (int i = 0; i < 30; i++) begin
      int m, sel;
      m = int'($urandom_range(0, 7));
      sel = int'($urandom_range(0, 2));
      if (sel == 0) begin
        wr(3'd0, DATA_W'(m));
        pE |= m[0]; uE |= m[1]; mE |= m[2];
        rd(3'd2, v); chk("R2 set mask", v, expStatus(pE, uE, mE, mdiv));
      end else if (sel == 1) begin
        wr(3'd1, DATA_W'(m));
        if (m[0]) pE = 0;
        if (m[1]) uE = 0;
        if (m[2]) mE = 0;
        rd(3'd2, v); chk("R3 clear mask", v, expStatus(pE, uE, mE, mdiv));
      end else begin
        mdiv = int'($urandom_range(0, 3));
        wr(3'd4, DATA_W'(mdiv));
        rd(3'd2, v); chk("R7 random mdiv", v, expStatus(pE, uE, mE, mdiv));
      end
    end

    // R4 disable waits for instruction boundary
    wr(3'd0, 32'h1);
    instrDone = 0;
    wr(3'd1, 32'h1);
    rd(3'd2, v); chk("R4 pending status", v & 1, 1);
    countProc(v); chk("R4 clock runs while pending", v, 10);
    @(negedge clk); instrDone = 1;
    @(negedge clk); instrDone = 0;
    rd(3'd2, v); chk("R4 stopped at boundary", v & 1, 0);
    countProc(v); chk("R10 proc off no edges", v, 0);

    // R5 masked interrupt has no effect, unmasked wakes
    irqMask = 8'h0F;
    @(negedge clk); irqReq = 8'h10;
    @(negedge clk); irqReq = 0;
    rd(3'd2, v); chk("R5 masked irq", v & 1, 0);
    countProc(v); chk("R5 masked irq clock", v, 0);
    irqReq = 8'h02;
    @(negedge clk); irqReq = 0;
    rd(3'd2, v); chk("R5 unmasked wake", v & 1, 1);
    countProc(v); chk("R5 woken clock", v, 10);

    // R5 wake cancels a pending disable
    wr(3'd1, 32'h1);
    irqReq = 8'h01;
    @(negedge clk); irqReq = 0;
    instrDone = 1;
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R5 pending cancelled", v & 1, 1);

    // R6/R7 memory clock
    wr(3'd0, 32'h4);
    wr(3'd4, 32'h0);
    rd(3'd2, v); chk("R7 forced off status", (v >> 2) & 1, 0);
    countMem(v); chk("R7 forced off edges", v, 0);
    wr(3'd4, 32'h3);
    rd(3'd2, v); chk("R7 restored status", (v >> 2) & 1, 1);
    countMem(v); chk("R6 double rate", v, 20);
    wr(3'd1, 32'h4);
    countMem(v); chk("R3 mem off edges", v, 0);

    // R8 USB divider, several values including 0
    wr(3'd0, 32'h2);
    for (int k = 0; k < 4; k++) begin
      int d;
      d = (k == 0) ? 0 : int'($urandom_range(1, 7));
      wr(3'd3, DATA_W'(d));
      repeat (20) @(negedge clk);
      countUsb((d + 1) * 16, a, b);
      chkRange("R8 usb48 count", a, 15, 17);
      chkRange("R8 usb12 count", b, 3, 5);
    end

    // R9 source select
    wr(3'd3, 32'h1);
    repeat (20) @(negedge clk);
    begin
      int s; s = n48; repeat (96) @(negedge clk); a = n48 - s;
    end
    chkRange("R9 source A", a, 58, 62);
    wr(3'd3, 32'h101);
    rd(3'd3, v); chk("R9 usbcfg readback", v, 32'h101);
    repeat (20) @(negedge clk);
    begin
      int s; s = n48; repeat (96) @(negedge clk); a = n48 - s;
    end
    chkRange("R9 source B", a, 38, 42);

    // R10 USB off
    wr(3'd1, 32'h2);
    repeat (20) @(negedge clk);
    countUsb(64, a, b);
    chk("R10 usb48 off", a, 0);
    chk("R10 usb12 off", b, 0);

    e = 0;
    $display("%0d/%0d checks passed", nChecks - nFails + e, nChecks);
    $finish;
  end
endmodule